// File: doc/BRIEF.md
# Fail-Safe Fault Error Counter

This block keeps the fault tally of a safety supervisor. Each monitored fault arrives as a one-cycle strobe. Each strobe carries its own configured impact on the two safety outputs: the reset output and the fail-safe output. A fault whose impact drives at least one of these outputs advances a saturating error counter.

A watchdog-error-counter-at-maximum strobe also advances the counter, but only while the fail-safe output is already asserted. Software requests can assert either safety output without touching the tally.

When the tally reaches a programmable intermediate threshold, the block raises a level flag and a one-cycle impact pulse. When the tally reaches its maximum and deep fail-safe is enabled, the block enters a latched deep fail-safe state. That state pins both safety outputs on until power-on reset. With deep fail-safe disabled, counting and the intermediate action still work; only the terminal state is withheld.

A separate regulator-enable latch is cleared by an overvoltage detect and set again by a wake-up event. The active-low power-on reset is applied asynchronously and released through a two-stage synchronizer.

Top module: `fs_fault_counter`

## Requirements
- R1: A cycle with one or more fault strobes whose impact includes reset or fail-safe raises the counter by exactly 1 on the next clock edge, however many such strobes coincide.
- R2: A fault strobe whose configured impact is neither reset nor fail-safe leaves the counter, `rst_out` and `fs_out` unchanged.
- R3: `sw_rst_req` and `sw_fs_req` assert `rst_out` and `fs_out` respectively on the next edge, and never change the counter.
- R4: `wd_max` raises the counter by 1 when `fs_out` is high in that cycle, and has no effect on the counter when `fs_out` is low.
- R5: A counted fault and a counted `wd_max` in the same cycle raise the counter by 2.
- R6: The counter saturates at `CNT_MAX` (default 6) and never exceeds it.
- R7: `mid_flag` is high whenever the counter is at or above `mid_thr`. `mid_pulse` is high for exactly the one cycle in which the counter first moves from below `mid_thr` to at or above it.
- R8: With `dfs_en` high, the counter reaching `CNT_MAX` sets `dfs_state` in that same cycle. This also holds when `dfs_en` rises while the counter already sits at the maximum. Once set, `dfs_state` holds `rst_out` and `fs_out` high, ignores `fs_clr`, and clears only on power-on reset.
- R9: With `dfs_en` low, the counter still advances and saturates, `mid_flag` and `mid_pulse` still behave as in R7, and `dfs_state` stays low.
- R10: `ov_det` clears `reg_en` on the next edge, and `reg_en` stays low until `wake` is seen. `ov_det` wins over `wake` in the same cycle.
- R11: After power-on reset, the counter is 0, `dfs_state`, `rst_out`, `fs_out`, `mid_flag` and `mid_pulse` are low, and `reg_en` is high.
- R12: Outside deep fail-safe, `rst_out` is a one-cycle pulse per set request. `fs_out` stays high after a set request until a cycle with `fs_clr` high and no new set request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| flt_evt | input | NFLT | One-cycle fault strobes |
| flt_imp_rst | input | NFLT | Per fault: impact includes the reset output |
| flt_imp_fs | input | NFLT | Per fault: impact includes the fail-safe output |
| sw_rst_req | input | 1 | Software request to assert the reset output |
| sw_fs_req | input | 1 | Software request to assert the fail-safe output |
| fs_clr | input | 1 | Release request for the fail-safe output |
| wd_max | input | 1 | Watchdog error counter reached its maximum |
| dfs_en | input | 1 | Deep fail-safe enable |
| mid_thr | input | CW | Intermediate threshold, 1 to CNT_MAX-1 |
| ov_det | input | 1 | Overvoltage detect |
| wake | input | 1 | Wake-up event |
| rst_out | output | 1 | Reset output asserted |
| fs_out | output | 1 | Fail-safe output asserted |
| cnt | output | CW | Fault error counter value |
| mid_flag | output | 1 | Counter at or above the threshold |
| mid_pulse | output | 1 | One-cycle threshold-crossing impact |
| dfs_state | output | 1 | Latched deep fail-safe state |
| reg_en | output | 1 | Regulator-enable latch |

## Verification
The checker assumes that `mid_thr` is held constant between resets and lies strictly between 0 and `CNT_MAX`. Its crossing-pulse property is meaningless if the threshold moves under a live count. The checker also assumes that `ov_det`, `wake` and the fault strobes stay low while the reset synchronizer is still releasing. The stimulus programs the threshold to 3 before reset release and never changes it. Every input change is made at least three cycles after `rst_n` rises. The per-fault impacts are set once, so each fault index has a fixed role: no impact, reset only, or fail-safe only.

// File: rtl/fs_fec_pkg.sv
package fs_fec_pkg;
  // Qualified events produced by the input stage in one cycle.
  typedef struct packed {
    logic set_rst;   // any request to assert the reset output
    logic set_fs;    // any request to assert the fail-safe output
    logic cnt_flt;   // fault with a safety impact: one count
    logic cnt_wd;    // watchdog saturation while fail-safe asserted
  } fec_evt_t;
endpackage

// File: rtl/fs_evt_qual.sv
module fs_evt_qual
  import fs_fec_pkg::*;
#(
  parameter int NFLT = 4
) (
  input  logic [NFLT-1:0] flt_evt,
  input  logic [NFLT-1:0] flt_imp_rst,
  input  logic [NFLT-1:0] flt_imp_fs,
  input  logic            sw_rst_req,
  input  logic            sw_fs_req,
  input  logic            wd_max,
  input  logic            fs_now,
  output fec_evt_t        evt
);
  logic [NFLT-1:0] hit_rst;
  logic [NFLT-1:0] hit_fs;

  for (genvar i = 0; i < NFLT; i++) begin : g_flt
    assign hit_rst[i] = flt_evt[i] & flt_imp_rst[i];
    assign hit_fs[i]  = flt_evt[i] & flt_imp_fs[i];
  end

  always_comb begin
    evt.cnt_flt = |(hit_rst | hit_fs);
    evt.set_rst = (|hit_rst) | sw_rst_req;
    evt.set_fs  = (|hit_fs) | sw_fs_req;
    evt.cnt_wd  = wd_max & fs_now;
  end
endmodule

// File: rtl/fs_err_counter.sv
module fs_err_counter #(
  parameter int CNT_MAX = 6,
  parameter int CW      = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_flt,
  input  logic          inc_wd,
  input  logic          dfs_en,
  input  logic [CW-1:0] mid_thr,
  output logic [CW-1:0] cnt,
  output logic          mid_flag,
  output logic          mid_pulse,
  output logic          dfs_state,
  output logic          dfs_enter
);
  localparam logic [CW:0]   MAX_W = (CW + 1)'(CNT_MAX);
  localparam logic [CW-1:0] MAX_V = CW'(CNT_MAX);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [CW:0]   sum;
  logic          cnt_en;
  logic          mid_q, mid_nxt;
  logic          dfs_q;

  always_comb begin
    sum     = {1'b0, cnt_q} + {{CW{1'b0}}, inc_flt} + {{CW{1'b0}}, inc_wd};
    cnt_nxt = (sum >= MAX_W) ? MAX_V : sum[CW-1:0];
    cnt_en  = inc_flt | inc_wd;
    mid_nxt = (cnt_q < mid_thr) && (cnt_nxt >= mid_thr);
    dfs_enter = dfs_en && (cnt_nxt == MAX_V) && !dfs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mid_q <= 1'b0;
      dfs_q <= 1'b0;
    end else begin
      if (cnt_en)    cnt_q <= cnt_nxt;
      mid_q <= mid_nxt;
      if (dfs_enter) dfs_q <= 1'b1;
    end
  end

  assign cnt       = cnt_q;
  assign mid_flag  = (cnt_q >= mid_thr);
  assign mid_pulse = mid_q;
  assign dfs_state = dfs_q;
endmodule

// File: rtl/fs_out_ctrl.sv
module fs_out_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_rst,
  input  logic set_fs,
  input  logic fs_clr,
  input  logic dfs_hold,
  input  logic ov_det,
  input  logic wake,
  output logic rst_out,
  output logic fs_out,
  output logic reg_en
);
  logic rst_q, rst_nxt;
  logic fs_q, fs_nxt;
  logic reg_q, reg_nxt;

  always_comb begin
    rst_nxt = dfs_hold | set_rst;
    fs_nxt  = dfs_hold | set_fs | (fs_q & ~fs_clr);
    if (ov_det)    reg_nxt = 1'b0;
    else if (wake) reg_nxt = 1'b1;
    else           reg_nxt = reg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      fs_q  <= 1'b0;
      reg_q <= 1'b1;
    end else begin
      rst_q <= rst_nxt;
      fs_q  <= fs_nxt;
      reg_q <= reg_nxt;
    end
  end

  assign rst_out = rst_q;
  assign fs_out  = fs_q;
  assign reg_en  = reg_q;
endmodule

// File: rtl/fs_fault_counter.sv
module fs_fault_counter
  import fs_fec_pkg::*;
#(
  parameter int NFLT    = 4,
  parameter int CNT_MAX = 6,
  localparam int CW     = $clog2(CNT_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLT-1:0] flt_evt,
  input  logic [NFLT-1:0] flt_imp_rst,
  input  logic [NFLT-1:0] flt_imp_fs,
  input  logic            sw_rst_req,
  input  logic            sw_fs_req,
  input  logic            fs_clr,
  input  logic            wd_max,
  input  logic            dfs_en,
  input  logic [CW-1:0]   mid_thr,
  input  logic            ov_det,
  input  logic            wake,
  output logic            rst_out,
  output logic            fs_out,
  output logic [CW-1:0]   cnt,
  output logic            mid_flag,
  output logic            mid_pulse,
  output logic            dfs_state,
  output logic            reg_en
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  fec_evt_t evt;
  logic     dfs_enter;

  fs_evt_qual #(.NFLT(NFLT)) u_qual (
    .flt_evt     (flt_evt),
    .flt_imp_rst (flt_imp_rst),
    .flt_imp_fs  (flt_imp_fs),
    .sw_rst_req  (sw_rst_req),
    .sw_fs_req   (sw_fs_req),
    .wd_max      (wd_max),
    .fs_now      (fs_out),
    .evt         (evt)
  );

  fs_err_counter #(.CNT_MAX(CNT_MAX), .CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .inc_flt   (evt.cnt_flt),
    .inc_wd    (evt.cnt_wd),
    .dfs_en    (dfs_en),
    .mid_thr   (mid_thr),
    .cnt       (cnt),
    .mid_flag  (mid_flag),
    .mid_pulse (mid_pulse),
    .dfs_state (dfs_state),
    .dfs_enter (dfs_enter)
  );

  fs_out_ctrl u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_rst  (evt.set_rst),
    .set_fs   (evt.set_fs),
    .fs_clr   (fs_clr),
    .dfs_hold (dfs_state | dfs_enter),
    .ov_det   (ov_det),
    .wake     (wake),
    .rst_out  (rst_out),
    .fs_out   (fs_out),
    .reg_en   (reg_en)
  );
endmodule

// File: rtl/fs_fault_counter_chk.sv
module fs_fault_counter_chk #(
  parameter int NFLT    = 4,
  parameter int CNT_MAX = 6,
  parameter int CW      = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NFLT-1:0] flt_evt,
  input logic [NFLT-1:0] flt_imp_rst,
  input logic [NFLT-1:0] flt_imp_fs,
  input logic            wd_max,
  input logic            dfs_en,
  input logic            fs_clr,
  input logic [CW-1:0]   mid_thr,
  input logic            ov_det,
  input logic            rst_out,
  input logic            fs_out,
  input logic [CW-1:0]   cnt,
  input logic            mid_flag,
  input logic            mid_pulse,
  input logic            dfs_state,
  input logic            reg_en
);
  logic flt_hit, wd_hit;
  assign flt_hit = |(flt_evt & (flt_imp_rst | flt_imp_fs));
  assign wd_hit  = wd_max & fs_out;

  // R6
  cnt_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CNT_MAX));

  // R1
  cnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt >= $past(cnt));

  // R3
  cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_hit && !wd_hit) |=> $stable(cnt));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt - $past(cnt)) <= CW'(2));

  // R8
  dfs_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dfs_state |=> dfs_state);

  // R8
  dfs_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dfs_state |-> (rst_out && fs_out && cnt == CW'(CNT_MAX)));

  // R9
  dfs_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dfs_state) |-> $past(dfs_en));

  // R8
  dfs_clr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dfs_state && fs_clr) |=> fs_out);

  // R7
  mid_pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_pulse |-> (mid_flag && !$past(mid_flag)));

  // R10
  ov_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_det |=> !reg_en);

  // R7
  thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_thr != '0) && (mid_thr < CW'(CNT_MAX)));
endmodule

bind fs_fault_counter fs_fault_counter_chk #(
  .NFLT(NFLT), .CNT_MAX(CNT_MAX), .CW(CW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flt_evt     (flt_evt),
  .flt_imp_rst (flt_imp_rst),
  .flt_imp_fs  (flt_imp_fs),
  .wd_max      (wd_max),
  .dfs_en      (dfs_en),
  .fs_clr      (fs_clr),
  .mid_thr     (mid_thr),
  .ov_det      (ov_det),
  .rst_out     (rst_out),
  .fs_out      (fs_out),
  .cnt         (cnt),
  .mid_flag    (mid_flag),
  .mid_pulse   (mid_pulse),
  .dfs_state   (dfs_state),
  .reg_en      (reg_en)
);

// File: tb/fs_fault_counter_test.sv
module fs_fault_counter_test;
  localparam int NFLT = 4;
  localparam int CW   = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [NFLT-1:0] flt_evt, flt_imp_rst, flt_imp_fs;
  logic sw_rst_req, sw_fs_req, fs_clr, wd_max, dfs_en, ov_det, wake;
  logic [CW-1:0] mid_thr;
  logic rst_out, fs_out, mid_flag, mid_pulse, dfs_state, reg_en;
  logic [CW-1:0] cnt;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  fs_fault_counter #(.NFLT(NFLT), .CNT_MAX(6)) uut (
    .clk(clk), .rst_n(rst_n), .flt_evt(flt_evt), .flt_imp_rst(flt_imp_rst),
    .flt_imp_fs(flt_imp_fs), .sw_rst_req(sw_rst_req), .sw_fs_req(sw_fs_req),
    .fs_clr(fs_clr), .wd_max(wd_max), .dfs_en(dfs_en), .mid_thr(mid_thr),
    .ov_det(ov_det), .wake(wake), .rst_out(rst_out), .fs_out(fs_out),
    .cnt(cnt), .mid_flag(mid_flag), .mid_pulse(mid_pulse),
    .dfs_state(dfs_state), .reg_en(reg_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    flt_evt = '0; sw_rst_req = 0; sw_fs_req = 0; fs_clr = 0;
    wd_max = 0; ov_det = 0; wake = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    dfs_en = 0;
    rst_n  = 0;
    repeat (2) cyc();
    rst_n = 1;
    repeat (3) cyc();
  endtask

  // fault 0: no impact, fault 1: reset only, faults 2 and 3: fail-safe only
  task automatic fire(input logic [NFLT-1:0] f, input logic wd);
    flt_evt = f; wd_max = wd;
    cyc();
    idle_inputs();
  endtask

  task automatic t_reset_state();
    chk("R11 cnt", cnt, 0);
    chk("R11 dfs_state", dfs_state, 0);
    chk("R11 rst_out", rst_out, 0);
    chk("R11 fs_out", fs_out, 0);
    chk("R11 mid_flag", mid_flag, 0);
    chk("R11 mid_pulse", mid_pulse, 0);
    chk("R11 reg_en", reg_en, 1);
  endtask

  task automatic t_no_impact();
    fire(4'b0001, 0);
    chk("R2 cnt", cnt, 0);
    chk("R2 rst_out", rst_out, 0);
    chk("R2 fs_out", fs_out, 0);
  endtask

  task automatic t_sw_and_wd();
    sw_rst_req = 1; cyc(); idle_inputs();
    chk("R3 rst_out", rst_out, 1);
    chk("R3 cnt after sw reset", cnt, 0);
    cyc();
    chk("R12 rst pulse ends", rst_out, 0);
    sw_fs_req = 1; cyc(); idle_inputs();
    chk("R3 fs_out", fs_out, 1);
    chk("R3 cnt after sw fs", cnt, 0);
    cyc();
    chk("R12 fs held", fs_out, 1);
    fire(4'b0000, 1);
    chk("R4 wd counted with fs high", cnt, 1);
    fs_clr = 1; cyc(); idle_inputs();
    chk("R12 fs released", fs_out, 0);
    fire(4'b0000, 1);
    chk("R4 wd ignored with fs low", cnt, 1);
  endtask

  task automatic t_fault_count();
    fire(4'b0010, 0);
    chk("R1 rst impact counted", cnt, 2);
    chk("R1 rst_out", rst_out, 1);
    chk("R7 below thr flag", mid_flag, 0);
    fire(4'b1100, 0);
    chk("R1 two coincident faults one count", cnt, 3);
    chk("R1 fs_out", fs_out, 1);
    chk("R7 flag at thr", mid_flag, 1);
    chk("R7 pulse at crossing", mid_pulse, 1);
    cyc();
    chk("R7 pulse one cycle", mid_pulse, 0);
    chk("R7 flag held", mid_flag, 1);
  endtask

  task automatic t_dual();
    fire(4'b0010, 1);
    chk("R5 fault plus wd", cnt, 5);
  endtask

  task automatic t_sat_nodfs();
    fire(4'b0010, 0);
    chk("R9 counts to max without dfs", cnt, 6);
    chk("R9 no dfs", dfs_state, 0);
    chk("R9 mid flag", mid_flag, 1);
    fire(4'b0010, 1);
    chk("R6 saturated", cnt, 6);
    chk("R9 still no dfs", dfs_state, 0);
  endtask

  task automatic t_dfs_late();
    dfs_en = 1; cyc();
    chk("R8 dfs on enable at max", dfs_state, 1);
    chk("R8 rst held", rst_out, 1);
    fs_clr = 1; cyc(); idle_inputs();
    chk("R8 fs_clr ignored", fs_out, 1);
    chk("R8 rst still held", rst_out, 1);
    chk("R8 dfs sticky", dfs_state, 1);
  endtask

  task automatic t_dfs_run();
    dfs_en = 1;
    for (int i = 0; i < 5; i++) fire(4'b0010, 0);
    chk("R8 cnt before max", cnt, 5);
    chk("R8 no dfs before max", dfs_state, 0);
    chk("R7 flag via dfs run", mid_flag, 1);
    fire(4'b0010, 0);
    chk("R8 cnt at max", cnt, 6);
    chk("R8 dfs with max", dfs_state, 1);
    chk("R8 fs forced", fs_out, 1);
  endtask

  task automatic t_regulator();
    ov_det = 1; cyc(); idle_inputs();
    chk("R10 ov clears", reg_en, 0);
    repeat (3) cyc();
    chk("R10 stays off", reg_en, 0);
    ov_det = 1; wake = 1; cyc(); idle_inputs();
    chk("R10 ov wins", reg_en, 0);
    wake = 1; cyc(); idle_inputs();
    chk("R10 wake restores", reg_en, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    flt_imp_rst = 4'b0010;
    flt_imp_fs  = 4'b1100;
    mid_thr     = 3'd3;
    do_reset();
    t_reset_state();
    t_no_impact();
    t_sw_and_wd();
    t_fault_count();
    t_dual();
    t_sat_nodfs();
    t_dfs_late();
    do_reset();
    t_reset_state();
    t_dfs_run();
    do_reset();
    t_regulator();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule